// File: doc/BRIEF.md
# 2D Blit Register Front-End

This block sits between a register write port and a 2D copy engine. It collects the geometry of the next operation: source and destination coordinates, rectangle width and height, surface base offsets, row pitches and tiling flags, and the drawing control word. Software can write each field on its own, or two fields at once through packed registers. Several packed registers carry the same pair of fields in different orders.

Only a write that carries a width starts an operation. Height and coordinates can therefore be staged in advance, and the final width write fires the engine. The start pulse is registered, so the engine sees the fully updated parameter set in the cycle the pulse is high. A `layoutSel` input chooses between two field layouts for offset and pitch. While the engine reports busy, the write port holds off new writes through `wrReady` and does not drop them.

Top module: `blit_reg_frontend`

## Requirements
- R1: After reset every stored field is zero, `startPulse` is low, and `wrReady` is high while `engineBusy` is low.
- R2: A write to a single coordinate register stores `wrData[13:0]`. The registers are source X at address 0, source Y at 1, destination X at 2, destination Y at 3, width at 4 and height at 5.
- R3: The Y/X packed registers (source 6, destination 7) take X from bits 13:0 and Y from bits 29:16. The X/Y packed registers (source 8, destination 9) take Y from bits 13:0 and X from bits 29:16.
- R4: These writes raise `startPulse` for exactly one cycle, in the cycle after the write is accepted, with the new fields already visible:
  - width at 4;
  - height/width at 10, with width in 13:0 and height in 29:16;
  - width/height at 11, with height in 13:0 and width in 29:16;
  - width/X at 12, with destination X in 13:0 and width in 29:16.
- R5: These writes store their fields and never raise `startPulse`: height alone at 5, height/Y at 13 (destination Y in 13:0, height in 29:16), and any coordinate register.
- R6: With `layoutSel`=0, a packed pitch/offset write (source 18, destination 19) sets offset = bits 20:0 shifted left by 5, pitch = bits 30:21 and tile = bit 31.
- R7: With `layoutSel`=1, a packed pitch/offset write sets offset = bits 21:0 shifted left by 10, pitch = bits 29:22 placed at pitch bits 13:6, and tile = bit 30.
- R8: A direct offset write (source 14, destination 16) is masked with 0xFFFFFFF0 when `layoutSel`=0 and with 0xFFFFFC00 when `layoutSel`=1.
- R9: A direct pitch write (source 15, destination 17) works as follows. With `layoutSel`=0 it keeps bits 13:0 as pitch and loads tile from bit 16. With `layoutSel`=1 it keeps only bits 13:4 and leaves tile unchanged.
- R10: A write to the control register at address 20 sets three fields:
  - `masterCtl` = data & 0xF800000F;
  - `dataType`: bits 11:8 go to 3:0, bits 7:4 go to 11:8, bits 13:12 go to 17:16, and bit 14 goes to bit 30;
  - `mixMode`: data bits 23:16 stay in place and bits 26:24 go to 10:8.
- R11: `wrReady` is low while `engineBusy` is high and during the `startPulse` cycle. A write held off in this way is accepted once `wrReady` returns high.
- R12: A write to an unmapped address, such as 31, changes no field and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| layoutSel | input | 1 | Offset/pitch field layout: 0 or 1 |
| engineBusy | input | 1 | Engine busy, holds off writes |
| wrValid | input | 1 | Write request |
| wrAddr | input | ADDR_W | Register word address |
| wrData | input | 32 | Write data |
| wrReady | output | 1 | Write accepted when high with wrValid |
| startPulse | output | 1 | One-cycle operation start |
| srcX | output | COORD_W | Source X |
| srcY | output | COORD_W | Source Y |
| dstX | output | COORD_W | Destination X |
| dstY | output | COORD_W | Destination Y |
| width | output | COORD_W | Rectangle width |
| height | output | COORD_W | Rectangle height |
| srcOffset | output | 32 | Source base offset |
| srcPitch | output | 14 | Source pitch |
| srcTile | output | 1 | Source tiling flag |
| dstOffset | output | 32 | Destination base offset |
| dstPitch | output | 14 | Destination pitch |
| dstTile | output | 1 | Destination tiling flag |
| masterCtl | output | 32 | Masked control word |
| dataType | output | 32 | Derived datatype field |
| mixMode | output | 32 | Derived mix field |

## Verification
The bench swaps lane order across the aliased packed registers. A design that mixes up Y/X and X/Y, or width/X and height/width, stores the wrong coordinate. It writes height and height/Y alone to catch a front end that launches on any size write, and it checks that every pulse lasts one cycle and comes after the data. It toggles `layoutSel` and puts ones in every data bit to expose a wrong shift, mask or tile bit position. It also checks that a tile bit set earlier survives a layout-1 pitch write. Finally, it holds `engineBusy` during a width write: a design that drops or accepts that write early shows the wrong width or the wrong pulse timing.

// File: rtl/blit_fe_pkg.sv
package blit_fe_pkg;

  localparam int REG_W     = 32;
  localparam int PITCH_W   = 14;
  localparam int NUM_COORD = 6;
  localparam int NUM_SIDE  = 2;

  // coordinate slots
  localparam int C_SRCX   = 0;
  localparam int C_SRCY   = 1;
  localparam int C_DSTX   = 2;
  localparam int C_DSTY   = 3;
  localparam int C_WIDTH  = 4;
  localparam int C_HEIGHT = 5;

  // surface sides
  localparam int S_SRC = 0;
  localparam int S_DST = 1;

  // register word addresses
  localparam logic [31:0] A_SRC_X        = 32'd0;
  localparam logic [31:0] A_SRC_Y        = 32'd1;
  localparam logic [31:0] A_DST_X        = 32'd2;
  localparam logic [31:0] A_DST_Y        = 32'd3;
  localparam logic [31:0] A_WIDTH        = 32'd4;
  localparam logic [31:0] A_HEIGHT       = 32'd5;
  localparam logic [31:0] A_SRC_YX       = 32'd6;
  localparam logic [31:0] A_DST_YX       = 32'd7;
  localparam logic [31:0] A_SRC_XY       = 32'd8;
  localparam logic [31:0] A_DST_XY       = 32'd9;
  localparam logic [31:0] A_HEIGHT_WIDTH = 32'd10;
  localparam logic [31:0] A_WIDTH_HEIGHT = 32'd11;
  localparam logic [31:0] A_WIDTH_X      = 32'd12;
  localparam logic [31:0] A_HEIGHT_Y     = 32'd13;
  localparam logic [31:0] A_SRC_OFF      = 32'd14;
  localparam logic [31:0] A_SRC_PITCH    = 32'd15;
  localparam logic [31:0] A_DST_OFF      = 32'd16;
  localparam logic [31:0] A_DST_PITCH    = 32'd17;
  localparam logic [31:0] A_SRC_PACK     = 32'd18;
  localparam logic [31:0] A_DST_PACK     = 32'd19;
  localparam logic [31:0] A_MASTER       = 32'd20;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_COORD-1:0] coordWr;
    logic [NUM_COORD-1:0] coordHi;
    logic [NUM_SIDE-1:0]  offWr;
    logic [NUM_SIDE-1:0]  pitchWr;
    logic [NUM_SIDE-1:0]  packWr;
    logic                 masterWr;
    logic                 launch;
  } strobe_t;

endpackage

// File: rtl/blit_fe_ctrl.sv
module blit_fe_ctrl
  import blit_fe_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              engineBusy,
  output logic              wrReady,
  output logic              startPulse,
  output strobe_t           strb
);

  logic        accept;
  logic [31:0] addrIdx;

  assign wrReady = !engineBusy && !startPulse;
  assign accept  = wrValid && wrReady;
  assign addrIdx = 32'(wrAddr);

  always_comb begin
    strb = '0;
    if (accept) begin
      case (addrIdx)
        A_SRC_X:  strb.coordWr[C_SRCX] = 1'b1;
        A_SRC_Y:  strb.coordWr[C_SRCY] = 1'b1;
        A_DST_X:  strb.coordWr[C_DSTX] = 1'b1;
        A_DST_Y:  strb.coordWr[C_DSTY] = 1'b1;
        A_WIDTH: begin
          strb.coordWr[C_WIDTH] = 1'b1;
          strb.launch           = 1'b1;
        end
        A_HEIGHT: strb.coordWr[C_HEIGHT] = 1'b1;
        A_SRC_YX: begin
          strb.coordWr[C_SRCX] = 1'b1;
          strb.coordWr[C_SRCY] = 1'b1;
          strb.coordHi[C_SRCY] = 1'b1;
        end
        A_DST_YX: begin
          strb.coordWr[C_DSTX] = 1'b1;
          strb.coordWr[C_DSTY] = 1'b1;
          strb.coordHi[C_DSTY] = 1'b1;
        end
        A_SRC_XY: begin
          strb.coordWr[C_SRCY] = 1'b1;
          strb.coordWr[C_SRCX] = 1'b1;
          strb.coordHi[C_SRCX] = 1'b1;
        end
        A_DST_XY: begin
          strb.coordWr[C_DSTY] = 1'b1;
          strb.coordWr[C_DSTX] = 1'b1;
          strb.coordHi[C_DSTX] = 1'b1;
        end
        A_HEIGHT_WIDTH: begin
          strb.coordWr[C_WIDTH]  = 1'b1;
          strb.coordWr[C_HEIGHT] = 1'b1;
          strb.coordHi[C_HEIGHT] = 1'b1;
          strb.launch            = 1'b1;
        end
        A_WIDTH_HEIGHT: begin
          strb.coordWr[C_HEIGHT] = 1'b1;
          strb.coordWr[C_WIDTH]  = 1'b1;
          strb.coordHi[C_WIDTH]  = 1'b1;
          strb.launch            = 1'b1;
        end
        A_WIDTH_X: begin
          strb.coordWr[C_DSTX]  = 1'b1;
          strb.coordWr[C_WIDTH] = 1'b1;
          strb.coordHi[C_WIDTH] = 1'b1;
          strb.launch           = 1'b1;
        end
        A_HEIGHT_Y: begin
          strb.coordWr[C_DSTY]   = 1'b1;
          strb.coordWr[C_HEIGHT] = 1'b1;
          strb.coordHi[C_HEIGHT] = 1'b1;
        end
        A_SRC_OFF:   strb.offWr[S_SRC]   = 1'b1;
        A_SRC_PITCH: strb.pitchWr[S_SRC] = 1'b1;
        A_DST_OFF:   strb.offWr[S_DST]   = 1'b1;
        A_DST_PITCH: strb.pitchWr[S_DST] = 1'b1;
        A_SRC_PACK:  strb.packWr[S_SRC]  = 1'b1;
        A_DST_PACK:  strb.packWr[S_DST]  = 1'b1;
        A_MASTER:    strb.masterWr       = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startPulse <= 1'b0;
    else       startPulse <= strb.launch;
  end

endmodule

// File: rtl/blit_fe_datapath.sv
module blit_fe_datapath
  import blit_fe_pkg::*;
#(
  parameter int COORD_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               layoutSel,
  input  logic [REG_W-1:0]   wrData,
  input  strobe_t            strb,
  output logic [COORD_W-1:0] coordQ [NUM_COORD],
  output logic [REG_W-1:0]   offQ   [NUM_SIDE],
  output logic [PITCH_W-1:0] pitchQ [NUM_SIDE],
  output logic               tileQ  [NUM_SIDE],
  output logic [REG_W-1:0]   masterQ,
  output logic [REG_W-1:0]   dataTypeQ,
  output logic [REG_W-1:0]   mixQ
);

  localparam int HI_LSB = REG_W / 2;
  localparam logic [REG_W-1:0] OFF_MASK0 = 32'hFFFF_FFF0;
  localparam logic [REG_W-1:0] OFF_MASK1 = 32'hFFFF_FC00;
  localparam logic [REG_W-1:0] CTL_MASK  = 32'hF800_000F;

  logic [COORD_W-1:0] loLane;
  logic [COORD_W-1:0] hiLane;

  assign loLane = wrData[COORD_W-1:0];
  assign hiLane = wrData[HI_LSB +: COORD_W];

  for (genvar c = 0; c < NUM_COORD; c++) begin : g_coord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                coordQ[c] <= '0;
      else if (strb.coordWr[c]) coordQ[c] <= strb.coordHi[c] ? hiLane : loLane;
    end
  end

  for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
    logic [REG_W-1:0]   offN;
    logic [PITCH_W-1:0] pitchN;
    logic               tileN;

    always_comb begin
      offN   = offQ[s];
      pitchN = pitchQ[s];
      tileN  = tileQ[s];
      if (strb.packWr[s]) begin
        if (!layoutSel) begin
          offN   = {6'b0, wrData[20:0], 5'b0};
          pitchN = {4'b0, wrData[30:21]};
          tileN  = wrData[31];
        end else begin
          offN   = {wrData[21:0], 10'b0};
          pitchN = {wrData[29:22], 6'b0};
          tileN  = wrData[30];
        end
      end else if (strb.offWr[s]) begin
        offN = wrData & (layoutSel ? OFF_MASK1 : OFF_MASK0);
      end else if (strb.pitchWr[s]) begin
        if (!layoutSel) begin
          pitchN = wrData[PITCH_W-1:0];
          tileN  = wrData[16];
        end else begin
          pitchN = {wrData[13:4], 4'b0};
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        offQ[s]   <= '0;
        pitchQ[s] <= '0;
        tileQ[s]  <= 1'b0;
      end else begin
        offQ[s]   <= offN;
        pitchQ[s] <= pitchN;
        tileQ[s]  <= tileN;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterQ   <= '0;
      dataTypeQ <= '0;
      mixQ      <= '0;
    end else if (strb.masterWr) begin
      masterQ   <= wrData & CTL_MASK;
      dataTypeQ <= {1'b0, wrData[14], 12'b0, wrData[13:12], 4'b0,
                    wrData[7:4], 4'b0, wrData[11:8]};
      mixQ      <= {8'b0, wrData[23:16], 5'b0, wrData[26:24], 8'b0};
    end
  end

endmodule

// File: rtl/blit_reg_frontend.sv
module blit_reg_frontend
  import blit_fe_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int COORD_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               layoutSel,
  input  logic               engineBusy,
  input  logic               wrValid,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [31:0]        wrData,
  output logic               wrReady,
  output logic               startPulse,
  output logic [COORD_W-1:0] srcX,
  output logic [COORD_W-1:0] srcY,
  output logic [COORD_W-1:0] dstX,
  output logic [COORD_W-1:0] dstY,
  output logic [COORD_W-1:0] width,
  output logic [COORD_W-1:0] height,
  output logic [31:0]        srcOffset,
  output logic [13:0]        srcPitch,
  output logic               srcTile,
  output logic [31:0]        dstOffset,
  output logic [13:0]        dstPitch,
  output logic               dstTile,
  output logic [31:0]        masterCtl,
  output logic [31:0]        dataType,
  output logic [31:0]        mixMode
);

  strobe_t            strb;
  logic [COORD_W-1:0] coordQ [NUM_COORD];
  logic [REG_W-1:0]   offQ   [NUM_SIDE];
  logic [PITCH_W-1:0] pitchQ [NUM_SIDE];
  logic               tileQ  [NUM_SIDE];

  blit_fe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrValid    (wrValid),
    .wrAddr     (wrAddr),
    .engineBusy (engineBusy),
    .wrReady    (wrReady),
    .startPulse (startPulse),
    .strb       (strb)
  );

  blit_fe_datapath #(.COORD_W(COORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .layoutSel (layoutSel),
    .wrData    (wrData),
    .strb      (strb),
    .coordQ    (coordQ),
    .offQ      (offQ),
    .pitchQ    (pitchQ),
    .tileQ     (tileQ),
    .masterQ   (masterCtl),
    .dataTypeQ (dataType),
    .mixQ      (mixMode)
  );

  assign srcX      = coordQ[C_SRCX];
  assign srcY      = coordQ[C_SRCY];
  assign dstX      = coordQ[C_DSTX];
  assign dstY      = coordQ[C_DSTY];
  assign width     = coordQ[C_WIDTH];
  assign height    = coordQ[C_HEIGHT];
  assign srcOffset = offQ[S_SRC];
  assign srcPitch  = pitchQ[S_SRC];
  assign srcTile   = tileQ[S_SRC];
  assign dstOffset = offQ[S_DST];
  assign dstPitch  = pitchQ[S_DST];
  assign dstTile   = tileQ[S_DST];

endmodule

// File: rtl/blit_fe_chk.sv
module blit_fe_chk
  import blit_fe_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int COORD_W = 14
) (
  input logic               clk,
  input logic               rstN,
  input logic               layoutSel,
  input logic               engineBusy,
  input logic               wrValid,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic               wrReady,
  input logic               startPulse,
  input logic [COORD_W-1:0] srcX,
  input logic [COORD_W-1:0] srcY,
  input logic [COORD_W-1:0] dstX,
  input logic [COORD_W-1:0] dstY,
  input logic [COORD_W-1:0] width,
  input logic [COORD_W-1:0] height,
  input logic               dstTile
);

  logic [31:0] addrIdx;
  logic        taken;
  logic        sizeLaunch;

  assign addrIdx    = 32'(wrAddr);
  assign taken      = wrValid && wrReady;
  assign sizeLaunch = (addrIdx == A_WIDTH) || (addrIdx == A_HEIGHT_WIDTH) ||
                      (addrIdx == A_WIDTH_HEIGHT) || (addrIdx == A_WIDTH_X);

  // R4
  start_after_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(taken && sizeLaunch));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  // R5
  no_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && !sizeLaunch) |=> !startPulse);

  // R11
  busy_holdoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    engineBusy |-> !wrReady);

  // R11
  pulse_holdoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> !wrReady);

  // R2
  coords_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !taken |=> ($stable(srcX) && $stable(srcY) && $stable(dstX) &&
                $stable(dstY) && $stable(width) && $stable(height)));

  // R9
  tile_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && layoutSel && addrIdx == A_DST_PITCH) |=> $stable(dstTile));

endmodule

bind blit_reg_frontend blit_fe_chk #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_chk (.*);

// File: tb/blit_reg_frontend_tb.sv
module blit_reg_frontend_tb;
  import blit_fe_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        layoutSel = 1'b0;
  logic        engineBusy = 1'b0;
  logic        wrValid = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        wrReady, startPulse, srcTile, dstTile;
  logic [13:0] srcX, srcY, dstX, dstY, width, height, srcPitch, dstPitch;
  logic [31:0] srcOffset, dstOffset, masterCtl, dataType, mixMode;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  blit_reg_frontend u_dut (
    .clk(clk), .rstN(rstN), .layoutSel(layoutSel), .engineBusy(engineBusy),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrReady(wrReady),
    .startPulse(startPulse), .srcX(srcX), .srcY(srcY), .dstX(dstX),
    .dstY(dstY), .width(width), .height(height), .srcOffset(srcOffset),
    .srcPitch(srcPitch), .srcTile(srcTile), .dstOffset(dstOffset),
    .dstPitch(dstPitch), .dstTile(dstTile), .masterCtl(masterCtl),
    .dataType(dataType), .mixMode(mixMode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lo14(input logic [31:0] d);
    return d & 32'h3FFF;
  endfunction

  function automatic logic [31:0] hi14(input logic [31:0] d);
    return (d >> 16) & 32'h3FFF;
  endfunction

  // returns at the falling edge after the accepting rising edge
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrAddr  = a[4:0];
    wrData  = d;
    while (!wrReady) @(negedge clk);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 srcX", 32'(srcX), 0);
    chk("R1 width", 32'(width), 0);
    chk("R1 dstOffset", dstOffset, 0);
    chk("R1 masterCtl", masterCtl, 0);
    chk("R1 startPulse", 32'(startPulse), 0);
    chk("R1 wrReady", 32'(wrReady), 1);
  endtask

  task automatic t_single;
    wr(A_SRC_X, 32'hFFFF_1234);
    chk("R2 srcX", 32'(srcX), 32'h1234);
    chk("R5 no pulse srcX", 32'(startPulse), 0);
    wr(A_SRC_Y, 32'h0000_7FFF);
    chk("R2 srcY masked", 32'(srcY), 32'h3FFF);
    wr(A_DST_X, 32'h0000_0101);
    chk("R2 dstX", 32'(dstX), 32'h0101);
    wr(A_DST_Y, 32'h0000_0202);
    chk("R2 dstY", 32'(dstY), 32'h0202);
    chk("R5 no pulse dstY", 32'(startPulse), 0);
  endtask

  task automatic t_packed;
    logic [31:0] d;
    d = 32'h1ABC_2DEF;
    wr(A_SRC_YX, d);
    chk("R3 srcYX x", 32'(srcX), lo14(d));
    chk("R3 srcYX y", 32'(srcY), hi14(d));
    d = 32'h0123_0456;
    wr(A_DST_XY, d);
    chk("R3 dstXY y", 32'(dstY), lo14(d));
    chk("R3 dstXY x", 32'(dstX), hi14(d));
    d = 32'hC777_0888;
    wr(A_SRC_XY, d);
    chk("R3 srcXY y", 32'(srcY), lo14(d));
    chk("R3 srcXY x", 32'(srcX), hi14(d));
    d = 32'h0055_0066;
    wr(A_DST_YX, d);
    chk("R3 dstYX x", 32'(dstX), lo14(d));
    chk("R3 dstYX y", 32'(dstY), hi14(d));
    chk("R5 no pulse packed", 32'(startPulse), 0);
  endtask

  task automatic t_launch;
    logic [31:0] d;
    wr(A_WIDTH, 32'h0000_0040);
    chk("R4 width pulse", 32'(startPulse), 1);
    chk("R4 width", 32'(width), 32'h40);
    @(negedge clk);
    chk("R4 pulse one cycle", 32'(startPulse), 0);
    d = 32'h0030_0020;
    wr(A_HEIGHT_WIDTH, d);
    chk("R4 hw pulse", 32'(startPulse), 1);
    chk("R4 hw width", 32'(width), lo14(d));
    chk("R4 hw height", 32'(height), hi14(d));
    d = 32'h0011_0022;
    wr(A_WIDTH_HEIGHT, d);
    chk("R4 wh pulse", 32'(startPulse), 1);
    chk("R4 wh height", 32'(height), lo14(d));
    chk("R4 wh width", 32'(width), hi14(d));
    d = 32'h3FFF_0123;
    wr(A_WIDTH_X, d);
    chk("R4 wx pulse", 32'(startPulse), 1);
    chk("R4 wx dstX", 32'(dstX), lo14(d));
    chk("R4 wx width", 32'(width), hi14(d));
  endtask

  task automatic t_stage;
    logic [31:0] d;
    wr(A_HEIGHT, 32'h0000_0099);
    chk("R5 height", 32'(height), 32'h99);
    chk("R5 height no pulse", 32'(startPulse), 0);
    d = 32'h0444_0333;
    wr(A_HEIGHT_Y, d);
    chk("R5 hy dstY", 32'(dstY), lo14(d));
    chk("R5 hy height", 32'(height), hi14(d));
    chk("R5 hy no pulse", 32'(startPulse), 0);
  endtask

  task automatic t_pack0;
    logic [31:0] d;
    layoutSel = 1'b0;
    d = 32'hFFFF_FFFF;
    wr(A_SRC_PACK, d);
    chk("R6 off", srcOffset, (d & 32'h1F_FFFF) << 5);
    chk("R6 pitch", 32'(srcPitch), (d >> 21) & 32'h3FF);
    chk("R6 tile", 32'(srcTile), 1);
    d = 32'h5234_5678;
    wr(A_DST_PACK, d);
    chk("R6 dst off", dstOffset, (d & 32'h1F_FFFF) << 5);
    chk("R6 dst pitch", 32'(dstPitch), (d >> 21) & 32'h3FF);
    chk("R6 dst tile", 32'(dstTile), d >> 31);
  endtask

  task automatic t_pack1;
    logic [31:0] d;
    @(negedge clk);
    layoutSel = 1'b1;
    d = 32'hFFFF_FFFF;
    wr(A_DST_PACK, d);
    chk("R7 off", dstOffset, (d & 32'h3F_FFFF) << 10);
    chk("R7 pitch", 32'(dstPitch), (d & 32'h3FC0_0000) >> 16);
    chk("R7 tile", 32'(dstTile), 1);
    d = 32'h8123_4567;
    wr(A_SRC_PACK, d);
    chk("R7 src off", srcOffset, (d & 32'h3F_FFFF) << 10);
    chk("R7 src pitch", 32'(srcPitch), (d & 32'h3FC0_0000) >> 16);
    chk("R7 src tile", 32'(srcTile), (d >> 30) & 1);
  endtask

  task automatic t_direct;
    @(negedge clk);
    layoutSel = 1'b0;
    wr(A_SRC_OFF, 32'hFFFF_FFFF);
    chk("R8 off mask0", srcOffset, 32'hFFFF_FFF0);
    wr(A_SRC_PITCH, 32'hFFFE_FFFF);
    chk("R9 pitch0", 32'(srcPitch), 32'h3FFF);
    chk("R9 tile0 from bit16", 32'(srcTile), 0);
    wr(A_DST_PITCH, 32'h0001_0005);
    chk("R9 dst tile0", 32'(dstTile), 1);
    @(negedge clk);
    layoutSel = 1'b1;
    wr(A_DST_OFF, 32'hFFFF_FFFF);
    chk("R8 off mask1", dstOffset, 32'hFFFF_FC00);
    wr(A_DST_PITCH, 32'h0000_FFFF);
    chk("R9 pitch1", 32'(dstPitch), 32'h3FF0);
    chk("R9 tile kept", 32'(dstTile), 1);
  endtask

  task automatic t_master;
    logic [31:0] d;
    logic [31:0] dt;
    logic [31:0] mx;
    for (int i = 0; i < 2; i++) begin
      d  = (i == 0) ? 32'hFFFF_FFFF : 32'h1234_5678;
      dt = ((d >> 8) & 32'hF) | ((d & 32'h30F0) << 4) | ((d & 32'h4000) << 16);
      mx = (d & 32'h00FF_0000) | ((d & 32'h0700_0000) >> 16);
      wr(A_MASTER, d);
      chk("R10 master", masterCtl, d & 32'hF800_000F);
      chk("R10 datatype", dataType, dt);
      chk("R10 mix", mixMode, mx);
    end
  endtask

  task automatic t_hold;
    logic [13:0] oldW;
    oldW = width;
    @(negedge clk);
    engineBusy = 1'b1;
    wrValid = 1'b1;
    wrAddr = A_WIDTH[4:0];
    wrData = 32'h0000_0777;
    repeat (3) @(negedge clk);
    chk("R11 ready low", 32'(wrReady), 0);
    chk("R11 no pulse busy", 32'(startPulse), 0);
    chk("R11 width held", 32'(width), 32'(oldW));
    engineBusy = 1'b0;
    @(negedge clk);
    wrValid = 1'b0;
    chk("R11 pulse after release", 32'(startPulse), 1);
    chk("R11 ready low in pulse", 32'(wrReady), 0);
    chk("R11 width taken", 32'(width), 32'h777);
  endtask

  task automatic t_unmapped;
    logic [13:0] w, x;
    logic [31:0] o;
    w = width; x = srcX; o = dstOffset;
    wr(32'd31, 32'hFFFF_FFFF);
    chk("R12 no pulse", 32'(startPulse), 0);
    chk("R12 width", 32'(width), 32'(w));
    chk("R12 srcX", 32'(srcX), 32'(x));
    chk("R12 dstOffset", dstOffset, o);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_packed();
    t_launch();
    t_stage();
    t_pack0();
    t_pack1();
    t_direct();
    t_master();
    t_hold();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule